// File: doc/BRIEF.md
# Boot-Layout Sector Map with Write Protection

This block sits between the command decoder of a byte-wide flash controller and its array sequencer. It takes a 20-bit byte address and works out which of the 19 erase blocks the address falls in. The blocks have uneven sizes: one 16 KB boot block, two 8 KB parameter blocks, one 32 KB block and fifteen 64 KB blocks. A parameter places the small blocks either at the high end of the address space (top layout) or at the low end (bottom layout). In each case the small blocks are mirror images of the other layout.

Every block has a protect flag held in a register. The flags come out of reset cleared. A command input sets or clears the flag of the currently addressed block. A program, block-erase, multi-block-erase or chip-erase request is checked against the flags. One cycle later the block returns:
- a grant or a refusal,
- the mask of blocks the sequencer may actually touch,
- an error flag.

Protected blocks are dropped from a multi-block or chip erase instead of aborting it. While a level indicator from the reset pin shows the raised voltage, the flags are bypassed for gating. The flags themselves are never rewritten, so protection returns as soon as the indicator drops. An identification read path returns the manufacturer code, the device code of the chosen layout, or the protect status of the addressed block.

Top module: `boot_sector_guard`

## Requirements
- R1: With the top layout, the small blocks are placed as follows: index 18 covers FC000h–FFFFFh, 17 covers FA000h–FBFFFh, 16 covers F8000h–F9FFFh and 15 covers F0000h–F7FFFh. Below F0000h, `blk_idx` equals address bits [19:16] (indices 0 to 14).
- R2: With the bottom layout, the small blocks are placed as follows: index 0 covers 00000h–03FFFh, 1 covers 04000h–05FFFh, 2 covers 06000h–07FFFh and 3 covers 08000h–0FFFFh. From 10000h up, `blk_idx` equals address bits [19:16] plus 3 (indices 4 to 18).
- R3: After reset every protect flag is 0 (unprotected), and `res_vld` is 0.
- R4: A cycle with `prot_cmd_vld` high writes `prot_cmd_set` into the flag of the block addressed in that cycle; `blk_prot` shows the new value from the next cycle. The flags of all other blocks are unchanged.
- R5: `mod_req_kind` 0 (program) and 1 (block erase) target the addressed block. One cycle after `mod_req_vld` there is a one-cycle `res_vld` pulse. In that pulse, `res_grant` is 1 and `res_mask` holds only that block's bit if the block is not protected; otherwise `res_grant` is 0, `res_mask` is 0 and `res_err` is 1.
- R6: `mod_req_kind` 2 (multi-block erase) selects the blocks set in `erase_sel`. `res_mask` is the selection with protected blocks removed, and `res_grant` is 1 if that mask is non-zero. `res_err` is 1 only if the selection is non-empty and every selected block is protected. An empty selection gives grant 0 and error 0.
- R7: `mod_req_kind` 3 (chip erase) selects all 19 blocks and skips the protected ones in the same way as R6.
- R8: While `tmp_unprot` is 1, protected blocks are granted as if unprotected. Once it returns to 0, the same requests are refused again without any command being issued.
- R9: `id_data` returns 20h when `id_sel`=0. When `id_sel`=1 it returns the device code: D2h for the top layout or DCh for the bottom layout. When `id_sel`=2 it returns 01h if the addressed block's flag is set and 00h otherwise. When `id_sel`=3 it returns 00h.
- R10: `blk_prot` and the `id_sel`=2 status show the stored flag, whatever the level of `tmp_unprot`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 20 | Byte address being decoded |
| prot_cmd_vld | input | 1 | Write the protect flag of the addressed block |
| prot_cmd_set | input | 1 | 1 protects, 0 unprotects |
| tmp_unprot | input | 1 | Temporary-unprotect level indicator |
| mod_req_vld | input | 1 | Modification request strobe |
| mod_req_kind | input | 2 | 0 program, 1 block erase, 2 multi-block erase, 3 chip erase |
| erase_sel | input | 19 | Block selection for a multi-block erase |
| id_sel | input | 2 | Identification read select |
| blk_idx | output | 5 | Index of the addressed block |
| blk_prot | output | 1 | Stored protect flag of the addressed block |
| id_data | output | 8 | Identification read data |
| res_vld | output | 1 | Request result valid (one cycle) |
| res_grant | output | 1 | At least one block may be modified |
| res_err | output | 1 | Non-empty request fully refused |
| res_mask | output | 19 | Blocks allowed to be modified |

## Verification
On every cycle, the assertions check four things:
- a granted mask never includes a block whose flag was set while the bypass was low;
- a result pulse follows each request by exactly one cycle;
- a flag only changes in the cycle after a command, and then to the commanded value;
- the decoded index never leaves the 19-block range.

Only the bench scenarios can show the rest: the exact block boundaries of both layouts, the skipping arithmetic of multi-block and chip erase, the error rule for an empty selection, and protection coming back after the bypass is released.

// File: rtl/bsg_pkg.sv
package bsg_pkg;
   localparam int BLK_COUNT = 19;
   localparam int BLK_IDX_W = $clog2(BLK_COUNT);

   typedef enum logic [1:0] {
      MOD_PROG   = 2'd0,
      MOD_BERASE = 2'd1,
      MOD_MERASE = 2'd2,
      MOD_CERASE = 2'd3
   } mod_kind_e;

   typedef enum logic [1:0] {
      ID_MFR    = 2'd0,
      ID_DEV    = 2'd1,
      ID_STATUS = 2'd2,
      ID_NONE   = 2'd3
   } id_sel_e;
endpackage

// File: rtl/bsg_addr_map.sv
module bsg_addr_map #(
   parameter int ADDR_W   = 20,
   parameter bit TOP_BOOT = 1'b1,
   parameter int NUM_BLK  = bsg_pkg::BLK_COUNT,
   parameter int IDX_W    = bsg_pkg::BLK_IDX_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [IDX_W-1:0]  blk_idx
);
   localparam int SEG_W   = 4;
   localparam int SUB_W   = 3;
   localparam int SEG_LSB = ADDR_W - SEG_W;
   localparam int SUB_LSB = SEG_LSB - SUB_W;
   localparam int SMALL_N = 4;

   if (ADDR_W != 20) begin : g_bad_addr
      $error("bsg_addr_map: layout defined for a 20-bit byte address");
   end
   if (NUM_BLK != 15 + SMALL_N) begin : g_bad_count
      $error("bsg_addr_map: block count must be 19");
   end

   logic [SEG_W-1:0] seg;
   logic [SUB_W-1:0] sub;
   logic             unused_low;

   assign seg        = addr[ADDR_W-1 -: SEG_W];
   assign sub        = addr[SEG_LSB-1 -: SUB_W];
   assign unused_low = ^addr[SUB_LSB-1:0];

   if (TOP_BOOT) begin : g_top
      always_comb begin
         if (seg != {SEG_W{1'b1}}) begin
            blk_idx = IDX_W'(seg);
         end else if (!sub[2]) begin
            blk_idx = IDX_W'(15);
         end else if (sub[1]) begin
            blk_idx = IDX_W'(18);
         end else if (sub[0]) begin
            blk_idx = IDX_W'(17);
         end else begin
            blk_idx = IDX_W'(16);
         end
      end
   end else begin : g_bottom
      always_comb begin
         if (seg != '0) begin
            blk_idx = IDX_W'(seg) + IDX_W'(SMALL_N - 1);
         end else if (sub[2]) begin
            blk_idx = IDX_W'(3);
         end else if (!sub[1]) begin
            blk_idx = IDX_W'(0);
         end else if (sub[0]) begin
            blk_idx = IDX_W'(2);
         end else begin
            blk_idx = IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/bsg_prot_bank.sv
module bsg_prot_bank #(
   parameter int NUM_BLK = bsg_pkg::BLK_COUNT,
   parameter int IDX_W   = bsg_pkg::BLK_IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_vld,
   input  logic               cmd_set,
   input  logic [IDX_W-1:0]   cmd_idx,
   output logic [NUM_BLK-1:0] flags
);
   if (NUM_BLK > (1 << IDX_W)) begin : g_bad_idx
      $error("bsg_prot_bank: index too narrow for block count");
   end

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_flag
      logic hit;
      assign hit = cmd_vld && (cmd_idx == IDX_W'(b));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flags[b] <= 1'b0;
         end else if (hit) begin
            flags[b] <= cmd_set;
         end
      end
   end

   // R4
   flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_idx < IDX_W'(NUM_BLK)) |=> flags[$past(cmd_idx)] == $past(cmd_set));
   // R4
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_vld |=> $stable(flags));
endmodule

// File: rtl/bsg_mod_gate.sv
module bsg_mod_gate #(
   parameter int NUM_BLK = bsg_pkg::BLK_COUNT,
   parameter int IDX_W   = bsg_pkg::BLK_IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_vld,
   input  bsg_pkg::mod_kind_e req_kind,
   input  logic [IDX_W-1:0]   req_idx,
   input  logic [NUM_BLK-1:0] req_sel,
   input  logic [NUM_BLK-1:0] flags,
   input  logic               tmp_unprot,
   output logic               res_vld,
   output logic               res_grant,
   output logic               res_err,
   output logic [NUM_BLK-1:0] res_mask
);
   import bsg_pkg::*;

   logic [NUM_BLK-1:0] one_hot;
   logic [NUM_BLK-1:0] wanted;
   logic [NUM_BLK-1:0] locked;
   logic [NUM_BLK-1:0] allowed;

   for (genvar b = 0; b < NUM_BLK; b++) begin : g_dec
      assign one_hot[b] = (req_idx == IDX_W'(b));
   end

   always_comb begin
      unique case (req_kind)
         MOD_PROG, MOD_BERASE: wanted = one_hot;
         MOD_MERASE:           wanted = req_sel;
         default:              wanted = {NUM_BLK{1'b1}};
      endcase
   end

   assign locked  = tmp_unprot ? '0 : flags;
   assign allowed = wanted & ~locked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_vld   <= 1'b0;
         res_grant <= 1'b0;
         res_err   <= 1'b0;
         res_mask  <= '0;
      end else begin
         res_vld   <= req_vld;
         res_grant <= req_vld && (allowed != '0);
         res_err   <= req_vld && (wanted != '0) && (allowed == '0);
         res_mask  <= req_vld ? allowed : '0;
      end
   end

   // R5
   res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> res_vld);
   // R5
   res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> (!res_vld && !res_grant && !res_err));
   // R6
   no_locked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !tmp_unprot) |=> (res_mask & $past(flags)) == '0);
   // R6
   err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_err |-> (!res_grant && res_mask == '0));
endmodule

// File: rtl/boot_sector_guard.sv
module boot_sector_guard #(
   parameter int         ADDR_W   = 20,
   parameter bit         TOP_BOOT = 1'b1,
   parameter logic [7:0] MFR_CODE = 8'h20,
   parameter logic [7:0] DEV_TOP  = 8'hD2,
   parameter logic [7:0] DEV_BOT  = 8'hDC
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [19:0] addr,
   input  logic        prot_cmd_vld,
   input  logic        prot_cmd_set,
   input  logic        tmp_unprot,
   input  logic        mod_req_vld,
   input  logic [1:0]  mod_req_kind,
   input  logic [18:0] erase_sel,
   input  logic [1:0]  id_sel,
   output logic [4:0]  blk_idx,
   output logic        blk_prot,
   output logic [7:0]  id_data,
   output logic        res_vld,
   output logic        res_grant,
   output logic        res_err,
   output logic [18:0] res_mask
);
   import bsg_pkg::*;

   localparam int         NUM_BLK = BLK_COUNT;
   localparam int         IDX_W   = BLK_IDX_W;
   localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOT;

   if (ADDR_W != 20) begin : g_bad_w
      $error("boot_sector_guard: port width fixed at 20 address bits");
   end

   logic [NUM_BLK-1:0] flags;

   bsg_addr_map #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT),
                  .NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_map (
      .addr    (addr),
      .blk_idx (blk_idx)
   );

   bsg_prot_bank #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_vld (prot_cmd_vld),
      .cmd_set (prot_cmd_set),
      .cmd_idx (blk_idx),
      .flags   (flags)
   );

   bsg_mod_gate #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_vld    (mod_req_vld),
      .req_kind   (mod_kind_e'(mod_req_kind)),
      .req_idx    (blk_idx),
      .req_sel    (erase_sel),
      .flags      (flags),
      .tmp_unprot (tmp_unprot),
      .res_vld    (res_vld),
      .res_grant  (res_grant),
      .res_err    (res_err),
      .res_mask   (res_mask)
   );

   assign blk_prot = flags[blk_idx];

   always_comb begin
      unique case (id_sel_e'(id_sel))
         ID_MFR:    id_data = MFR_CODE;
         ID_DEV:    id_data = DEV_CODE;
         ID_STATUS: id_data = {7'd0, blk_prot};
         default:   id_data = 8'h00;
      endcase
   end

   // R1
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_idx < IDX_W'(NUM_BLK));
   // R8
   bypass_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_req_vld && tmp_unprot && mod_req_kind == 2'd3) |=> res_mask == {NUM_BLK{1'b1}});
endmodule

// File: tb/boot_sector_guard_tb.sv
`timescale 1ns/1ps
module boot_sector_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [19:0] addr = '0;
   logic        prot_cmd_vld = 1'b0, prot_cmd_set = 1'b0, tmp_unprot = 1'b0;
   logic        mod_req_vld = 1'b0;
   logic [1:0]  mod_req_kind = '0, id_sel = '0;
   logic [18:0] erase_sel = '0;
   logic [4:0]  blk_idx, b_idx;
   logic        blk_prot, b_prot;
   logic [7:0]  id_data, b_id;
   logic        res_vld, res_grant, res_err, b_vld, b_grant, b_err;
   logic [18:0] res_mask, b_mask;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic        c_vld, c_grant, c_err;
   logic [18:0] c_mask;

   always #2 clk = ~clk;

   boot_sector_guard #(.TOP_BOOT(1'b1)) u_dut (
      .clk, .rst_n, .addr, .prot_cmd_vld, .prot_cmd_set, .tmp_unprot,
      .mod_req_vld, .mod_req_kind, .erase_sel, .id_sel,
      .blk_idx, .blk_prot, .id_data, .res_vld, .res_grant, .res_err, .res_mask);

   boot_sector_guard #(.TOP_BOOT(1'b0)) u_dut_bot (
      .clk, .rst_n, .addr, .prot_cmd_vld, .prot_cmd_set, .tmp_unprot,
      .mod_req_vld, .mod_req_kind, .erase_sel, .id_sel,
      .blk_idx(b_idx), .blk_prot(b_prot), .id_data(b_id), .res_vld(b_vld),
      .res_grant(b_grant), .res_err(b_err), .res_mask(b_mask));

   // {address, top-layout index, bottom-layout index}
   localparam logic [29:0] DEC_VEC [19] = '{
      {20'h00000, 5'd0,  5'd0},  {20'h03FFF, 5'd0,  5'd0},
      {20'h04000, 5'd0,  5'd1},  {20'h05FFF, 5'd0,  5'd1},
      {20'h06000, 5'd0,  5'd2},  {20'h07FFF, 5'd0,  5'd2},
      {20'h08000, 5'd0,  5'd3},  {20'h0FFFF, 5'd0,  5'd3},
      {20'h10000, 5'd1,  5'd4},  {20'h7A5A5, 5'd7,  5'd10},
      {20'hEFFFF, 5'd14, 5'd17}, {20'hF0000, 5'd15, 5'd18},
      {20'hF7FFF, 5'd15, 5'd18}, {20'hF8000, 5'd16, 5'd18},
      {20'hF9FFF, 5'd16, 5'd18}, {20'hFA000, 5'd17, 5'd18},
      {20'hFBFFF, 5'd17, 5'd18}, {20'hFC000, 5'd18, 5'd18},
      {20'hFFFFF, 5'd18, 5'd18}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic prot(input logic [19:0] a, input logic set);
      @(negedge clk);
      addr = a; prot_cmd_set = set; prot_cmd_vld = 1'b1;
      @(negedge clk);
      prot_cmd_vld = 1'b0;
   endtask

   task automatic req(input logic [1:0] kind, input logic [19:0] a, input logic [18:0] sel);
      @(negedge clk);
      addr = a; mod_req_kind = kind; erase_sel = sel; mod_req_vld = 1'b1;
      @(negedge clk);
      c_vld = res_vld; c_grant = res_grant; c_err = res_err; c_mask = res_mask;
      mod_req_vld = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R3 reset state
      addr = 20'hFC000; #1; chk("R3 prot top", blk_prot, 1'b0);
      addr = 20'h50000; #1; chk("R3 prot mid", blk_prot, 1'b0);
      chk("R3 res_vld", res_vld, 1'b0);

      // R1 R2 decode table
      for (int i = 0; i < 19; i++) begin
         addr = DEC_VEC[i][29:10]; #1;
         chk($sformatf("R1 idx @%h", addr), blk_idx, DEC_VEC[i][9:5]);
         chk($sformatf("R2 idx @%h", addr), b_idx, DEC_VEC[i][4:0]);
      end

      // R4 protect blocks 18 and 5
      prot(20'hFD123, 1'b1);
      prot(20'h50000, 1'b1);
      addr = 20'hFFFFF; #1; chk("R4 blk18 set", blk_prot, 1'b1);
      addr = 20'h5ABCD; #1; chk("R4 blk5 set", blk_prot, 1'b1);
      addr = 20'h40000; #1; chk("R4 blk4 untouched", blk_prot, 1'b0);

      // R5 program / block erase
      req(2'd0, 20'hFC010, '0);
      chk("R5 prot vld", c_vld, 1'b1); chk("R5 prot grant", c_grant, 1'b0);
      chk("R5 prot err", c_err, 1'b1); chk("R5 prot mask", c_mask, 19'h0);
      req(2'd0, 20'h40000, '0);
      chk("R5 open grant", c_grant, 1'b1); chk("R5 open err", c_err, 1'b0);
      chk("R5 open mask", c_mask, 19'h00010);
      @(negedge clk); chk("R5 pulse ends", res_vld, 1'b0);
      req(2'd1, 20'h50000, '0);
      chk("R5 berase denied", c_grant, 1'b0); chk("R5 berase err", c_err, 1'b1);

      // R6 multi-block erase
      req(2'd2, 20'h0, 19'h40028);
      chk("R6 skip mask", c_mask, 19'h00008); chk("R6 skip grant", c_grant, 1'b1);
      chk("R6 skip err", c_err, 1'b0);
      req(2'd2, 20'h0, 19'h40020);
      chk("R6 all prot err", c_err, 1'b1); chk("R6 all prot grant", c_grant, 1'b0);
      chk("R6 all prot mask", c_mask, 19'h0);
      req(2'd2, 20'h0, 19'h0);
      chk("R6 empty err", c_err, 1'b0); chk("R6 empty grant", c_grant, 1'b0);

      // R7 chip erase
      req(2'd3, 20'h0, 19'h0);
      chk("R7 chip mask", c_mask, 19'h3FFDF); chk("R7 chip grant", c_grant, 1'b1);

      // R8 R10 temporary unprotect
      @(negedge clk); tmp_unprot = 1'b1;
      req(2'd0, 20'hFC000, '0);
      chk("R8 tmp grant", c_grant, 1'b1); chk("R8 tmp mask", c_mask, 19'h40000);
      req(2'd3, 20'h0, '0);
      chk("R8 tmp chip mask", c_mask, 19'h7FFFF);
      addr = 20'hFC000; id_sel = 2'd2; #1;
      chk("R10 flag kept", blk_prot, 1'b1); chk("R10 status kept", id_data, 8'h01);
      @(negedge clk); tmp_unprot = 1'b0;
      req(2'd0, 20'hFC000, '0);
      chk("R8 restored deny", c_grant, 1'b0); chk("R8 restored err", c_err, 1'b1);

      // R4 unprotect block 5
      prot(20'h50000, 1'b0);
      #1 chk("R4 blk5 clear", blk_prot, 1'b0);
      req(2'd1, 20'h50000, '0);
      chk("R4 blk5 erasable", c_mask, 19'h00020);

      // R9 identification
      id_sel = 2'd0; #1;
      chk("R9 mfr top", id_data, 8'h20); chk("R9 mfr bot", b_id, 8'h20);
      id_sel = 2'd1; #1;
      chk("R9 dev top", id_data, 8'hD2); chk("R9 dev bot", b_id, 8'hDC);
      id_sel = 2'd2; addr = 20'hFE000; #1; chk("R9 status set", id_data, 8'h01);
      addr = 20'h40000; #1; chk("R9 status clear", id_data, 8'h00);
      id_sel = 2'd3; #1; chk("R9 unused sel", id_data, 8'h00);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule